// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between the register file and a 32-bit data memory that is addressed in bytes. For each memory request it adds a sign-extended 16-bit displacement to a 32-bit base value to form the effective address. It then decides which byte lanes of the memory word are involved. For stores it copies the low byte or halfword of the source value into every matching lane and raises only the write strobes it needs.

The memory returns read data one cycle after the read strobe. The unit keeps the lane position and access kind of each load for that cycle. When the word comes back, it pulls out the addressed byte, halfword or word and widens it to 32 bits, using either sign or zero extension as the opcode selects.

A word access whose address is not 4-byte aligned is refused, and so is a halfword access at an odd address. The unit flags the fault and issues no memory traffic for that request.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `base` plus `offset` sign-extended to 32 bits, computed modulo 2^32, in the same cycle as the request.
- R2: Opcode values decoded: 32 signed byte load, 33 signed halfword load, 35 word load, 36 unsigned byte load, 37 unsigned halfword load, 40 byte store, 41 halfword store, 43 word store. Any other opcode produces no read, no write and no address error.
- R3: Lanes are little-endian. `mem_wstrb` bit n enables bits 8n+7..8n. A byte store sets only bit `mem_addr[1:0]`. A halfword store sets 4'b0011 when `mem_addr[1]` is 0 and 4'b1100 when it is 1. A word store sets 4'b1111. `mem_wstrb` is nonzero exactly when `mem_we` is high.
- R4: Store data is replicated across the lanes. A byte store drives `{4{store_data[7:0]}}` on `mem_wdata`, a halfword store drives `{2{store_data[15:0]}}`, and a word store drives `store_data`.
- R5: A word access with `mem_addr[1:0]` not zero, or a halfword access with `mem_addr[0]` set, raises `addr_err` in the request cycle. That request then asserts neither `mem_re` nor `mem_we`, and it produces no `load_valid` in the following cycle.
- R6: An accepted load raises `mem_re` in the request cycle. `load_valid` is high in exactly the next cycle and in no other.
- R7: Load result, taken from the word `mem_rdata` presented in the `load_valid` cycle and using the lane given by the request address:
  - A byte load returns bits 8L+7..8L, where L is `mem_addr[1:0]`. The signed form fills the upper 24 bits with bit 7 of that byte; the unsigned form fills them with zeros.
  - A halfword load returns the upper half of the word when `mem_addr[1]` is 1 and the lower half otherwise, extended to 32 bits in the same signed or unsigned way.
  - A word load returns the whole word.
- R8: `load_data` is zero in every cycle where `load_valid` is low.
- R9: While `rst_n` is low and after its release, `load_valid` is low until a load is accepted.
- R10: With `req_valid` low, `mem_re`, `mem_we` and `addr_err` stay low whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A memory request is presented this cycle |
| opcode | input | 6 | Major opcode of the request |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Effective byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wstrb | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_re` |
| addr_err | output | 1 | Misaligned access refused |
| load_valid | output | 1 | `load_data` holds a load result |
| load_data | output | 32 | Extended load result |

## Verification
The bound checker watches several rules on every cycle:
- the write strobe is present exactly when `mem_we` is, and it always has a legal shape;
- a single-lane strobe points at the lane given by the address;
- a full-word write is aligned;
- a refused access makes no memory request;
- an idle cycle is quiet;
- `load_valid` follows every read by exactly one cycle, and `load_data` is zero whenever `load_valid` is low.

The sweeps cover what only stimulus can show. They run every opcode through every lane offset with several data patterns, and cover address wraparound and negative displacements. From these they check the arithmetic value of the effective address, the replicated write data, and the sign or zero extension of each lane. They also confirm that the 56 unused opcodes do nothing.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int XLEN = 32,
  parameter int DISP_W = 16,
  parameter int OP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [XLEN-1:0]   base,
  input  logic [DISP_W-1:0] offset,
  input  logic [XLEN-1:0]   store_data,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [XLEN/8-1:0] mem_wstrb,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              addr_err,
  output logic              load_valid,
  output logic [XLEN-1:0]   load_data
);
  localparam int LANES = XLEN / 8;
  localparam int LW = $clog2(LANES);
  localparam logic [OP_W-1:0] OP_LB = 6'd32, OP_LH = 6'd33, OP_LW = 6'd35,
                              OP_LBU = 6'd36, OP_LHU = 6'd37,
                              OP_SB = 6'd40, OP_SH = 6'd41, OP_SW = 6'd43;

  logic is_ld, is_st, sz_b, sz_h, sz_w, uns;

  always_comb begin
    {is_ld, is_st, sz_b, sz_h, sz_w, uns} = '0;
    case (opcode)
      OP_LB:  {is_ld, sz_b} = 2'b11;
      OP_LBU: {is_ld, sz_b, uns} = 3'b111;
      OP_LH:  {is_ld, sz_h} = 2'b11;
      OP_LHU: {is_ld, sz_h, uns} = 3'b111;
      OP_LW:  {is_ld, sz_w} = 2'b11;
      OP_SB:  {is_st, sz_b} = 2'b11;
      OP_SH:  {is_st, sz_h} = 2'b11;
      OP_SW:  {is_st, sz_w} = 2'b11;
      default: ;
    endcase
  end

  logic [XLEN-1:0] ea;
  logic [LW-1:0] lane;
  logic misal, go;
  logic [LANES-1:0] lanes;

  assign ea = base + {{(XLEN-DISP_W){offset[DISP_W-1]}}, offset};
  assign lane = ea[LW-1:0];
  assign misal = (sz_w && lane != '0) || (sz_h && lane[0]);
  assign go = req_valid && !misal;

  assign mem_addr = ea;
  assign addr_err = req_valid && (is_ld || is_st) && misal;
  assign mem_re = go && is_ld;
  assign mem_we = go && is_st;

  always_comb begin
    if (sz_b)      lanes = LANES'(1) << lane;
    else if (sz_h) lanes = lane[1] ? 4'b1100 : 4'b0011;
    else           lanes = '1;
  end

  assign mem_wstrb = mem_we ? lanes : '0;
  assign mem_wdata = sz_b ? {LANES{store_data[7:0]}}
                   : sz_h ? {(LANES/2){store_data[15:0]}}
                   : store_data;

  logic pend, p_b, p_h, p_uns;
  logic [LW-1:0] p_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      p_b <= 1'b0;
      p_h <= 1'b0;
      p_uns <= 1'b0;
      p_lane <= '0;
    end else begin
      pend <= mem_re;
      if (mem_re) begin
        p_b <= sz_b;
        p_h <= sz_h;
        p_uns <= uns;
        p_lane <= lane;
      end
    end
  end

  logic [7:0] rd_b;
  logic [15:0] rd_h;
  logic [XLEN-1:0] ext;

  assign rd_b = mem_rdata[8*p_lane +: 8];
  assign rd_h = p_lane[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    if (p_b)      ext = {{(XLEN-8){!p_uns && rd_b[7]}}, rd_b};
    else if (p_h) ext = {{(XLEN-16){!p_uns && rd_h[15]}}, rd_h};
    else          ext = mem_rdata;
  end

  assign load_valid = pend;
  assign load_data = pend ? ext : '0;
endmodule

module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] mem_addr,
  input logic        mem_re,
  input logic        mem_we,
  input logic [3:0]  mem_wstrb,
  input logic        addr_err,
  input logic        load_valid,
  input logic [31:0] load_data
);
  assert_strobe_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> mem_wstrb == 4'b0000);
  assert_write_has_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wstrb == 4'b1111 || mem_wstrb == 4'b0011 ||
                mem_wstrb == 4'b1100 || $countones(mem_wstrb) == 1));
  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_wstrb) == 1) |-> mem_wstrb[mem_addr[1:0]]);
  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wstrb == 4'b1111) |-> mem_addr[1:0] == 2'b00);
  assert_err_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!mem_re && !mem_we));
  assert_read_then_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> load_valid);
  assert_valid_from_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(mem_re));
  assert_data_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> load_data == 32'd0);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_re && !mem_we && !addr_err));
endmodule

bind lsu_lane_align lsu_lane_align_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_addr(mem_addr),
  .mem_re(mem_re), .mem_we(mem_we), .mem_wstrb(mem_wstrb), .addr_err(addr_err),
  .load_valid(load_valid), .load_data(load_data)
);

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [5:0] opcode = '0;
  logic [31:0] base = '0, store_data = '0, mem_rdata = '0;
  logic [15:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic mem_re, mem_we, addr_err, load_valid;
  logic [3:0] mem_wstrb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [5:0] op, logic [31:0] b, logic [15:0] off,
                     logic [31:0] sd, logic [31:0] rd);
    logic [31:0] ea, wd, ld;
    logic [3:0] st;
    logic ld_op, st_op, bad;
    int sz;
    logic [1:0] l;
    ld_op = (op == 32 || op == 33 || op == 35 || op == 36 || op == 37);
    st_op = (op == 40 || op == 41 || op == 43);
    sz = (op == 32 || op == 36 || op == 40) ? 1 :
         (op == 33 || op == 37 || op == 41) ? 2 : 4;
    ea = b + 32'(signed'(off));
    l = ea[1:0];
    bad = (ld_op || st_op) && ((sz == 4 && l != 0) || (sz == 2 && l[0]));
    st = (!st_op || bad) ? 4'b0 : sz == 1 ? 4'(1 << l) :
         sz == 2 ? (l[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    wd = sz == 1 ? sd[7:0] * 32'h01010101 : sz == 2 ? sd[15:0] * 32'h00010001 : sd;
    if (sz == 1) ld = (rd >> (8 * l)) & 32'hFF;
    else if (sz == 2) ld = (rd >> (8 * l)) & 32'hFFFF;
    else ld = rd;
    if (op == 32 && ld[7]) ld = ld - 32'd256;
    if (op == 33 && ld[15]) ld = ld - 32'd65536;
    @(negedge clk);
    req_valid = 1'b1; opcode = op; base = b; offset = off; store_data = sd;
    #1;
    chk("R1 addr", mem_addr, ea);
    chk("R5 err", {31'b0, addr_err}, {31'b0, bad});
    chk("R6 re", {31'b0, mem_re}, {31'b0, ld_op && !bad});
    chk("R2/R3 we", {31'b0, mem_we}, {31'b0, st_op && !bad});
    chk("R3 strobe", {28'b0, mem_wstrb}, {28'b0, st});
    if (st_op && !bad) chk("R4 wdata", mem_wdata, wd);
    @(negedge clk);
    req_valid = 1'b0; mem_rdata = rd;
    #1;
    chk("R6 valid", {31'b0, load_valid}, {31'b0, ld_op && !bad});
    chk("R7/R8 data", load_data, (ld_op && !bad) ? ld : 32'd0);
    @(negedge clk);
    #1;
    chk("R6 one cycle", {31'b0, load_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [8] = '{6'd32, 6'd33, 6'd35, 6'd36, 6'd37, 6'd40, 6'd41, 6'd43};
    logic [31:0] pats [3] = '{32'h80FF7F01, 32'h7F8001FE, 32'hC3A55A3C};
    #5;
    #1 chk("R9 reset valid", {31'b0, load_valid}, 32'd0);
    chk("R8 reset data", load_data, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R9 after reset", {31'b0, load_valid}, 32'd0);
    for (int o = 0; o < 8; o++)
      for (int ln = 0; ln < 4; ln++)
        for (int p = 0; p < 3; p++) begin
          run(ops[o], 32'h20000008, 16'hFFF0 + 16'(ln), pats[p] ^ 32'h5A5A0000, pats[p]);
          run(ops[o], 32'h00001000 + 32'(p), 16'h7FF0 + 16'(ln) - 16'(p), pats[p], ~pats[p]);
        end
    run(6'd35, 32'hFFFFFFFF, 16'h0001, 32'h0, 32'h12345678);
    run(6'd43, 32'h00000004, 16'h8000, 32'hDEADBEEF, 32'h0);
    for (int op = 0; op < 64; op++)
      run(6'(op), 32'h00000101, 16'h0002, 32'hFFFFFFFF, 32'hFFFFFFFF);
    @(negedge clk);
    opcode = 6'd35; base = 32'h1; offset = 16'h0; store_data = 32'h1;
    #1 chk("R10 idle re", {31'b0, mem_re}, 32'd0);
    chk("R10 idle err", {31'b0, addr_err}, 32'd0);
    opcode = 6'd43;
    #1 chk("R10 idle we", {31'b0, mem_we}, 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule